// File: doc/BRIEF.md
# Console Serial Port with One-Character Receive Buffer

This block is a console port that a processor reaches through a small memory-mapped window. It has two byte-wide registers. One address loads a control byte when written and returns a status byte when read. The other address returns the buffered received character when read, and sends a character when written. Characters arrive on a ready/valid input stream and are held in a single-entry buffer. Written characters leave at once on an output stream that never stalls, so the transmitter always reports itself empty.

Only two parts of the control byte do anything. The top bit enables the receive interrupt. The two bits below it, when they hold the value 01, enable the transmit interrupt. The interrupt request output is a register and goes to an external priority controller. A receive interrupt also sets a flag bit in the status byte. A read of the data register clears the receive buffer, that flag and the request, all in one step.

Top module: `con_acia_port`

## Requirements
- R1: After reset, the control byte is 0, the status byte reads 0x02, the receive buffer is empty, `irq` is low and `rx_ready` is high.
- R2: The status byte places receive-full at bit 0 and transmit-empty at bit 1, which is always 1. The interrupt flag is at bit 7, and bits 6 to 2 read 0. A transmit interrupt never sets bit 7.
- R3: When the buffer is full, control bit 7 is 1 and status bit 7 is 0, the next clock edge sets status bit 7 and drives `irq` high.
- R4: The port accepts a receive byte only while the buffer is empty. `rx_ready` is low while the buffer is full, and a held character is never overwritten.
- R5: A read of the data register returns the buffered character. At the same clock edge it empties the buffer, clears status bits 0 and 7, and drives `irq` low.
- R6: Each data-register write puts the byte on `tx_data` with `tx_valid` high for exactly the following cycle. If control bits 6:5 equal 01, the write also leaves `irq` high after that edge; for any other value it leaves `irq` unchanged.
- R7: Offset 0 is the status/control register and offset 2 is the data register. Writes to offsets 1 and 3 have no effect, and reads from them return 0x00.
- R8: A read of the data register while the buffer is empty returns 0xFF.
- R9: Reset asserted during operation restores the R1 state, which discards a held character and withdraws `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the port window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| rx_valid | input | 1 | Receive stream byte present |
| rx_data | input | 8 | Receive stream byte |
| rx_ready | output | 1 | Port can take a receive byte |
| tx_valid | output | 1 | Transmit stream byte present (one-cycle pulse) |
| tx_data | output | 8 | Transmit stream byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The transmit path is tried with all 256 control bytes, each followed by a data write. This separates the single field value that enables the transmit interrupt from every other value, and it shows that the status flag stays clear. The receive path is tried with all 256 character values. The receive enable alternates between on and off, which separates interrupt behaviour from plain buffering and checks that each character comes back unchanged. Directed patterns then cover a second arrival while the buffer is full, a read from an empty buffer, accesses to the undecoded offsets, and a reset that arrives with a character held.

// File: rtl/con_acia_pkg.sv
package con_acia_pkg;
    localparam int BYTE_W     = 8;
    localparam int ST_RXFULL  = 0;
    localparam int ST_TXEMPTY = 1;
    localparam int ST_IRQ     = 7;
    localparam int CT_RXIE    = 7;
    localparam int CT_TXF_LO  = 5;
    localparam logic [1:0] TXIE_CODE = 2'b01;
    localparam logic [BYTE_W-1:0] EMPTY_READ = 8'hFF;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] rxbuf;
        logic              full;
        logic              flag;
        logic              irq;
        logic              tx_vld;
        logic [BYTE_W-1:0] tx_dat;
    } port_state_t;
endpackage

// File: rtl/con_acia_decode.sv
module con_acia_decode #(
    parameter int ADDR_W = 2
) (
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        stat_byte,
    input  logic [7:0]        data_byte,
    output logic              wr_ctrl,
    output logic              rd_stat,
    output logic              wr_data,
    output logic              rd_data,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] STAT_OFS = '0;
    localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(2);

    logic hit_stat, hit_data;

    always_comb begin
        hit_stat = bus_req && (bus_addr == STAT_OFS);
        hit_data = bus_req && (bus_addr == DATA_OFS);
        wr_ctrl  = hit_stat &&  bus_we;
        rd_stat  = hit_stat && !bus_we;
        wr_data  = hit_data &&  bus_we;
        rd_data  = hit_data && !bus_we;
        if (rd_stat)      rdata = stat_byte;
        else if (rd_data) rdata = data_byte;
        else              rdata = 8'h00;
    end
endmodule

// File: rtl/con_acia_core.sv
module con_acia_core
    import con_acia_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_data,
    input  logic              rd_data,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] stat_byte,
    output logic [BYTE_W-1:0] data_byte,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);
    port_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.tx_vld = 1'b0;
        rx_ready    = !st_q.full;

        if (wr_ctrl) st_d.ctrl = wdata;

        if (wr_data) begin
            st_d.tx_vld = 1'b1;
            st_d.tx_dat = wdata;
            if (st_q.ctrl[CT_TXF_LO+1:CT_TXF_LO] == TXIE_CODE)
                st_d.irq = 1'b1;
        end

        if (rd_data) begin
            st_d.full = 1'b0;
            st_d.flag = 1'b0;
            st_d.irq  = 1'b0;
        end else if (st_q.full && st_q.ctrl[CT_RXIE] && !st_q.flag) begin
            st_d.flag = 1'b1;
            st_d.irq  = 1'b1;
        end

        if (rx_valid && rx_ready) begin
            st_d.full  = 1'b1;
            st_d.rxbuf = rx_data;
        end

        stat_byte             = '0;
        stat_byte[ST_RXFULL]  = st_q.full;
        stat_byte[ST_TXEMPTY] = 1'b1;
        stat_byte[ST_IRQ]     = st_q.flag;
        data_byte             = st_q.full ? st_q.rxbuf : EMPTY_READ;
        tx_valid              = st_q.tx_vld;
        tx_data               = st_q.tx_dat;
        irq                   = st_q.irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a held character survives until it is read
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        (st_q.full && !rd_data) |=> $stable(st_q.rxbuf));
    // R5: data read clears flag and request
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_data |=> (!st_q.flag && !st_q.irq));
    // R6: transmit interrupt raised by data write when enabled
    a_r6_tx_irq: assert property (@(posedge clk) disable iff (rst)
        (wr_data && st_q.ctrl[CT_TXF_LO+1:CT_TXF_LO] == TXIE_CODE) |=> st_q.irq);
    // R2: the status flag only exists alongside a held character
    a_r2_flag_needs_full: assert property (@(posedge clk) disable iff (rst)
        st_q.flag |-> st_q.full);
    // R3: a newly set flag comes with the request
    a_r3_flag_raises_irq: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.flag) |-> st_q.irq);
endmodule

// File: rtl/con_acia_port.sv
module con_acia_port #(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    logic       wr_ctrl, rd_stat, wr_data, rd_data;
    logic [7:0] stat_byte, data_byte;

    con_acia_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .stat_byte (stat_byte),
        .data_byte (data_byte),
        .wr_ctrl   (wr_ctrl),
        .rd_stat   (rd_stat),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .rdata     (bus_rdata)
    );

    con_acia_core u_core (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .wdata     (bus_wdata),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .stat_byte (stat_byte),
        .data_byte (data_byte),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .irq       (irq)
    );

    // R7: at most one decoded register per access
    a_r7_single_decode: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_ctrl, rd_stat, wr_data, rd_data}));
endmodule

// File: tb/con_acia_port_bench.sv
`timescale 1ns/1ps
module con_acia_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, tx_valid, irq;
    logic [7:0] tx_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    con_acia_port u_con_acia_port (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [1:0] a,
                          input logic [7:0] d, output logic [7:0] r);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #2 r = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, output logic rdy);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        #2 rdy = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        logic [7:0] r;
        logic       rdy;
        do_reset();
        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 rx_ready", rx_ready, 1);
        access(0, 2'd0, 8'h00, r); check("R1 status", r, 8'h02);
        // R8 empty read
        access(0, 2'd2, 8'h00, r); check("R8 empty data read", r, 8'hFF);

        // R6/R2 transmit sweep over every control byte
        for (int c = 0; c < 256; c++) begin
            access(0, 2'd2, 8'h00, r);
            access(1, 2'd0, 8'(c), r);
            access(1, 2'd2, 8'(c) ^ 8'h5A, r);
            check("R6 tx_valid", tx_valid, 1);
            check("R6 tx_data", tx_data, (c ^ 8'h5A) & 8'hFF);
            check("R6 irq", irq, (((c >> 5) & 3) == 1) ? 1 : 0);
            @(negedge clk);
            check("R6 tx pulse one cycle", tx_valid, 0);
            access(0, 2'd0, 8'h00, r);
            check("R2 status after tx", r, 8'h02);
        end

        // R3/R5/R2 receive sweep over every byte
        for (int b = 0; b < 256; b++) begin
            access(0, 2'd2, 8'h00, r);
            access(1, 2'd0, (b & 1) ? 8'h80 : 8'h00, r);
            push(8'(b), rdy);
            check("R4 ready when empty", rdy, 1);
            @(negedge clk);
            check("R3 irq", irq, b & 1);
            access(0, 2'd0, 8'h00, r);
            check("R2 status full", r, (b & 1) ? 8'h83 : 8'h03);
            access(0, 2'd2, 8'h00, r);
            check("R5 data", r, b);
            check("R5 irq cleared", irq, 0);
            access(0, 2'd0, 8'h00, r);
            check("R5 status cleared", r, 8'h02);
        end

        // R4 second byte while full is refused
        access(1, 2'd0, 8'h00, r);
        push(8'hA1, rdy);
        push(8'hB2, rdy);
        check("R4 ready low when full", rdy, 0);
        access(0, 2'd2, 8'h00, r); check("R4 held byte kept", r, 8'hA1);
        access(0, 2'd2, 8'h00, r); check("R8 empty after read", r, 8'hFF);

        // R7 undecoded offsets
        access(1, 2'd1, 8'h20, r);
        access(1, 2'd3, 8'h77, r);
        check("R7 no tx on offset 3", tx_valid, 0);
        access(1, 2'd2, 8'h11, r);
        check("R7 offset 1 did not load ctrl", irq, 0);
        access(0, 2'd1, 8'h00, r); check("R7 read offset 1", r, 8'h00);
        access(0, 2'd3, 8'h00, r); check("R7 read offset 3", r, 8'h00);

        // R9 reset mid-operation
        access(1, 2'd0, 8'h80, r);
        push(8'h3C, rdy);
        @(negedge clk);
        check("R9 irq before reset", irq, 1);
        do_reset();
        check("R9 irq after reset", irq, 0);
        check("R9 rx_ready after reset", rx_ready, 1);
        access(0, 2'd0, 8'h00, r); check("R9 status after reset", r, 8'h02);
        access(1, 2'd2, 8'h44, r);
        check("R9 ctrl cleared", irq, 0);
        access(0, 2'd2, 8'h00, r); check("R9 buffer discarded", r, 8'hFF);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule